// File: doc/BRIEF.md
# Hold/Acknowledge Bus Master Requester

This block lets a DMA-style master borrow a shared system bus through a two-wire request/grant handshake. An internal engine posts a transfer as a number of accesses and a direction. The block raises a bus request (`hold`), waits until the arbiter's grant (`hlda`) is sampled high on a rising bus clock edge, and then runs the accesses back to back. Every access has an address cycle and a data cycle; a write adds one data-hold cycle. While it runs, the block drives a two-bit status code and the output enables for the address/strobe and data lines.

The arbiter can take the bus back in the middle of a transfer by dropping the grant. The grant is checked at the rising edge that ends the address cycle. If it is low there, the access in flight completes, no further access starts, and the request is dropped. The number of accesses still to do is kept. The request is raised again only after the grant has been seen low, so that the transfer can resume. A request is never raised while the grant is still seen high from an earlier owner. A configuration input chooses whether `hold` changes on the rising or the falling bus clock edge.

Top module: `bus_hold_master`

## Requirements
- R1: While `rst` is high on a rising edge, `hold`, `addr_oe`, `data_oe` and `xfer_busy` are 0 and `bus_status` is IDLE (2'b00) after that edge.
- R2: `xfer_start` is taken only when no transfer is pending and `xfer_count` is not zero. A start with a zero count, or one given while a transfer is pending, has no effect on the accesses run.
- R3: If `hlda` is sampled high when a start is taken, `hold` stays 0 until `hlda` is sampled low. It is then requested from the following rising edge.
- R4: The first access of each bus tenure begins at the rising edge after the one at which `hlda` is first sampled high while requesting.
- R5: A read access lasts 2 cycles (address, data) and a write access lasts 3 (address, data, hold). Accesses follow each other with no gap, so an uninterrupted transfer of N accesses keeps the bus busy for exactly N·2 or N·3 cycles.
- R6: `bus_status` is 2'b01 during every cycle of a read access, 2'b10 during every cycle of a write access, and 2'b00 otherwise. IDLE therefore appears right after the data cycle of a final read and right after the hold cycle of a final write.
- R7: `addr_oe` is 1 exactly in access cycles. `data_oe` is 1 only in the data and hold cycles of write accesses. Both are 0 whenever the request is not active.
- R8: If `hlda` is sampled low at the edge that ends an address cycle, that access completes and no further access starts in this tenure. The request is then dropped at the same edge at which `bus_status` returns to IDLE.
- R9: After such a pre-emption the accesses not yet done are kept. `hold` is raised again after `hlda` is sampled low, and the total number of access cycles still equals the requested count times the access length.
- R10: With `cfg_hold_fall` = 0, `hold` rises and falls at the rising edge. With `cfg_hold_fall` = 1, both changes come at the following falling edge, half a cycle later.
- R11: Once raised, `hold` stays high through every access cycle of the tenure, and `xfer_busy` is 1 from the accepted start until the last access ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_hold_fall | input | 1 | 1: `hold` changes on the falling edge; 0: on the rising edge |
| xfer_start | input | 1 | Transfer request pulse from the engine |
| xfer_write | input | 1 | Direction of the transfer, 1 = write |
| xfer_count | input | CNT_W | Number of accesses in the transfer |
| hlda | input | 1 | Grant from the bus arbiter |
| hold | output | 1 | Bus request to the arbiter |
| bus_status | output | 2 | 00 idle, 01 read access, 10 write access |
| addr_oe | output | 1 | Output enable for address and strobe lines |
| data_oe | output | 1 | Output enable for data lines |
| xfer_busy | output | 1 | A transfer is pending or running |

## Verification
The main sweep covers both directions, transfers of one to three accesses, grants given at once or two cycles late, and both edge settings. It runs each with no pre-emption, with pre-emption in the first access, and with pre-emption in the last access. Late grants separate a design that starts on the grant from one that starts on its own request. Pre-emption in the first access of a longer transfer must split the bus activity into two tenures with the same total cycle count. Pre-emption in the last access must look like a plain finish. Separate cases cover a start while the grant is still high from an earlier owner, a zero-count start, and a start given during a running transfer, which must leave the cycle count and status codes unchanged.

// File: rtl/bhm_pkg.sv
`timescale 1ns/1ps
package bhm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAITLO = 3'd1,
    ST_REQ    = 3'd2,
    ST_ADDR   = 3'd3,
    ST_DATA   = 3'd4,
    ST_WHOLD  = 3'd5
  } bhm_state_e;

  localparam logic [1:0] BST_IDLE  = 2'b00;
  localparam logic [1:0] BST_READ  = 2'b01;
  localparam logic [1:0] BST_WRITE = 2'b10;

  function automatic logic in_access(input bhm_state_e s);
    return (s == ST_ADDR) || (s == ST_DATA) || (s == ST_WHOLD);
  endfunction

  function automatic logic owns_bus(input bhm_state_e s);
    return (s == ST_REQ) || in_access(s);
  endfunction

endpackage

// File: rtl/bhm_seq.sv
`timescale 1ns/1ps
module bhm_seq
  import bhm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wr,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             hlda,
  output bhm_state_e       state_q,
  output bhm_state_e       state_d,
  output logic             dir_q,
  output logic             dir_d
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q, rem_d;
  logic             pre_q, pre_d;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    dir_d   = dir_q;
    pre_d   = pre_q;
    case (state_q)
      ST_IDLE: begin
        if (start && (start_cnt != '0)) begin
          rem_d   = start_cnt;
          dir_d   = start_wr;
          pre_d   = 1'b0;
          state_d = hlda ? ST_WAITLO : ST_REQ;
        end
      end
      ST_WAITLO: if (!hlda) state_d = ST_REQ;
      ST_REQ:    if (hlda)  state_d = ST_ADDR;
      ST_ADDR: begin
        pre_d   = !hlda;
        state_d = ST_DATA;
      end
      ST_DATA, ST_WHOLD: begin
        if ((state_q == ST_DATA) && dir_q) begin
          state_d = ST_WHOLD;
        end else if (rem_q == ONE) begin
          rem_d   = '0;
          state_d = ST_IDLE;
        end else begin
          rem_d   = rem_q - ONE;
          state_d = pre_q ? ST_WAITLO : ST_ADDR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      dir_q   <= 1'b0;
      pre_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      dir_q   <= dir_d;
      pre_q   <= pre_d;
    end
  end

  AST_REQ_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REQ && $past(state_q) != ST_REQ) |-> !$past(hlda)); // R3
  AST_ACCESS_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADDR && $past(state_q) == ST_REQ) |-> $past(hlda)); // R4
  AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA) |-> ($past(state_q) == ST_ADDR)); // R5
  AST_PREEMPT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADDR && !hlda) |=> ##1 (state_q != ST_ADDR)); // R8
  AST_REMAINDER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAITLO) |-> (rem_q != '0)); // R9

endmodule

// File: rtl/bhm_outreg.sv
`timescale 1ns/1ps
module bhm_outreg
  import bhm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bhm_state_e state_d,
  input  logic       dir_d,
  output logic       hold_q,
  output logic [1:0] status_q,
  output logic       addr_oe_q,
  output logic       data_oe_q,
  output logic       busy_q
);

  logic       acc_d;
  logic [1:0] status_d;

  always_comb begin
    acc_d    = in_access(state_d);
    status_d = BST_IDLE;
    if (acc_d) status_d = dir_d ? BST_WRITE : BST_READ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= 1'b0;
      status_q  <= BST_IDLE;
      addr_oe_q <= 1'b0;
      data_oe_q <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      hold_q    <= owns_bus(state_d);
      status_q  <= status_d;
      addr_oe_q <= acc_d;
      data_oe_q <= dir_d && ((state_d == ST_DATA) || (state_d == ST_WHOLD));
      busy_q    <= (state_d != ST_IDLE);
    end
  end

  AST_OE_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hold_q |-> (!addr_oe_q && !data_oe_q)); // R7
  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (status_q == BST_IDLE) |-> (!data_oe_q && !addr_oe_q)); // R6
  AST_HOLD_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> busy_q); // R11

endmodule

// File: rtl/bhm_hold_edge.sv
`timescale 1ns/1ps
module bhm_hold_edge (
  input  logic clk,
  input  logic rst,
  input  logic cfg_fall,
  input  logic hold_rise,
  output logic hold
);

  logic hold_fall;

  always_ff @(negedge clk) begin
    if (rst) hold_fall <= 1'b0;
    else     hold_fall <= hold_rise;
  end

  assign hold = cfg_fall ? hold_fall : hold_rise;

  AST_FALL_TRACKS_RISE: assert property (@(posedge clk) disable iff (rst)
    hold_fall == hold_rise); // R10

endmodule

// File: rtl/bus_hold_master.sv
`timescale 1ns/1ps
module bus_hold_master
  import bhm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_hold_fall,
  input  logic             xfer_start,
  input  logic             xfer_write,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic             hlda,
  output logic             hold,
  output logic [1:0]       bus_status,
  output logic             addr_oe,
  output logic             data_oe,
  output logic             xfer_busy
);

  bhm_state_e state_q, state_d;
  logic       dir_q, dir_d, hold_rise;

  bhm_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (xfer_start),
    .start_wr  (xfer_write),
    .start_cnt (xfer_count),
    .hlda      (hlda),
    .state_q   (state_q),
    .state_d   (state_d),
    .dir_q     (dir_q),
    .dir_d     (dir_d)
  );

  bhm_outreg u_out (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .dir_d     (dir_d),
    .hold_q    (hold_rise),
    .status_q  (bus_status),
    .addr_oe_q (addr_oe),
    .data_oe_q (data_oe),
    .busy_q    (xfer_busy)
  );

  bhm_hold_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .cfg_fall  (cfg_hold_fall),
    .hold_rise (hold_rise),
    .hold      (hold)
  );

  AST_WAIT_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAITLO) |-> !hold_rise); // R3
  AST_ACCESS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    in_access(state_q) |-> (hold_rise && addr_oe)); // R11
  AST_STATUS_DIR: assert property (@(posedge clk) disable iff (rst)
    in_access(state_q) |-> (bus_status == (dir_q ? BST_WRITE : BST_READ))); // R6

endmodule

// File: tb/test_bus_hold_master.sv
`timescale 1ns/1ps
module test_bus_hold_master;

  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_hold_fall = 1'b0;
  logic             xfer_start = 1'b0;
  logic             xfer_write = 1'b0;
  logic [CNT_W-1:0] xfer_count = '0;
  logic             hlda = 1'b0;
  logic             hold;
  logic [1:0]       bus_status;
  logic             addr_oe, data_oe, xfer_busy;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_hold_master #(.CNT_W(CNT_W)) i_bus_hold_master (
    .clk(clk), .rst(rst), .cfg_hold_fall(cfg_hold_fall),
    .xfer_start(xfer_start), .xfer_write(xfer_write), .xfer_count(xfer_count),
    .hlda(hlda), .hold(hold), .bus_status(bus_status),
    .addr_oe(addr_oe), .data_oe(data_oe), .xfer_busy(xfer_busy)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Moves to 3 ns after the next rising edge; inputs are driven there.
  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  task automatic run_case(input bit wr, input int n, input bit fall,
                          input int gd, input int pre);
    int len, busy_cnt, code_bad, oe_bad, hold_bad, edge_bad, start_bad;
    int segs, rises, gcyc, wait_n, exp_segs, pos;
    bit need_low, prev_busy, prev_hb, hb, ha, bsy, bz, aoe, doe, done_flag, pre_done;
    logic [1:0] sa, exp_code;
    len = wr ? 3 : 2;
    exp_code = wr ? 2'b10 : 2'b01;
    busy_cnt = 0; code_bad = 0; oe_bad = 0; hold_bad = 0; edge_bad = 0;
    start_bad = 0; segs = 0; rises = 0; gcyc = -10; wait_n = 0;
    need_low = 0; prev_busy = 0; prev_hb = 0; done_flag = 0; pre_done = 0;
    exp_segs = (pre >= 0 && pre < n - 1) ? 2 : 1;
    cfg_hold_fall = fall;
    xfer_write = wr;
    xfer_count = CNT_W'(n);
    xfer_start = 1'b1;
    for (int cyc = 0; cyc < 300 && !done_flag; cyc++) begin
      @(posedge clk); #1;
      sa = bus_status; aoe = addr_oe; doe = data_oe; ha = hold; bz = xfer_busy;
      #2;
      hb = hold;
      bsy = (sa != 2'b00);
      if (bsy) begin
        pos = busy_cnt % len;
        if (sa != exp_code) code_bad++;
        if (!aoe || (doe != (wr && pos != 0))) oe_bad++;
        if (!ha || !hb || !bz) hold_bad++;
        if (!prev_busy) begin
          segs++;
          if (cyc != gcyc + 1) start_bad++;
        end
        busy_cnt++;
      end else if (aoe || doe) begin
        oe_bad++;
      end
      if (hb && !prev_hb) begin
        rises++;
        if (ha != !fall) edge_bad++;
      end
      if (prev_busy && !bsy && (hb || (ha != fall))) edge_bad++;
      // ignored start while a transfer runs (R2)
      xfer_start = bsy && (busy_cnt == 2);
      if (xfer_start) begin
        xfer_count = CNT_W'(3);
        xfer_write = !wr;
      end
      if (pre >= 0 && !pre_done && bsy && (busy_cnt - 1 == pre * len)) begin
        hlda = 1'b0; need_low = 1; pre_done = 1;
      end else if (hlda && !hb) begin
        hlda = 1'b0;
      end else if (!hlda && hb && !need_low) begin
        if (wait_n == gd) begin
          hlda = 1'b1; gcyc = cyc;
        end else begin
          wait_n++;
        end
      end
      if (!hb) begin
        need_low = 0; wait_n = 0;
      end
      prev_busy = bsy; prev_hb = hb;
      if (busy_cnt == n * len && !bsy && !hb && !hlda && !bz) done_flag = 1;
    end
    xfer_start = 1'b0;
    chk(done_flag, "R5", "transfer completed in time", int'(done_flag), 1);
    chk(busy_cnt == n * len, "R5 R2", "access cycles", busy_cnt, n * len);
    chk(code_bad == 0, "R6", "status code mismatches", code_bad, 0);
    chk(oe_bad == 0, "R7", "output enable mismatches", oe_bad, 0);
    chk(start_bad == 0, "R4", "tenure start not one edge after grant", start_bad, 0);
    chk(hold_bad == 0, "R11", "hold/busy low inside access", hold_bad, 0);
    chk(edge_bad == 0, "R10", "hold edge mismatches", edge_bad, 0);
    chk(segs == exp_segs, "R8", "bus tenures", segs, exp_segs);
    chk(rises == exp_segs, "R9", "hold requests", rises, exp_segs);
  endtask

  initial begin
    // R1: reset state
    repeat (3) tick();
    chk(hold == 0 && addr_oe == 0 && data_oe == 0 && xfer_busy == 0, "R1",
        "outputs during reset", int'({hold, addr_oe, data_oe, xfer_busy}), 0);
    chk(bus_status == 2'b00, "R1", "status during reset", int'(bus_status), 0);
    rst = 1'b0;
    tick();

    // R2: zero-count start is ignored
    begin
      int bad;
      bad = 0;
      xfer_start = 1'b1; xfer_count = '0; xfer_write = 1'b0;
      for (int i = 0; i < 5; i++) begin
        tick();
        xfer_start = 1'b0;
        if (hold || xfer_busy || bus_status != 2'b00) bad++;
      end
      chk(bad == 0, "R2", "zero-count start activity", bad, 0);
    end

    // R3: grant already high when the start is taken
    begin
      int bad;
      bad = 0;
      cfg_hold_fall = 1'b0;
      hlda = 1'b1;
      xfer_start = 1'b1; xfer_count = CNT_W'(1); xfer_write = 1'b0;
      for (int i = 0; i < 4; i++) begin
        tick();
        xfer_start = 1'b0;
        if (hold || !xfer_busy) bad++;
      end
      chk(bad == 0, "R3", "hold raised while grant high", bad, 0);
      hlda = 1'b0;
      tick();
      chk(hold == 1'b1, "R3", "hold one edge after grant low", int'(hold), 1);
      hlda = 1'b1;
      tick();
      chk(bus_status == 2'b01, "R3", "read access after late grant", int'(bus_status), 1);
      tick();
      tick();
      chk(bus_status == 2'b00 && hold == 1'b0, "R6", "idle after final read data cycle",
          int'({bus_status, hold}), 0);
      hlda = 1'b0;
      tick();
    end

    // main sweep
    for (int f = 0; f < 2; f++)
      for (int w = 0; w < 2; w++)
        for (int n = 1; n <= 3; n++)
          for (int g = 0; g <= 2; g += 2)
            for (int p = 0; p < 3; p++)
              run_case(w[0], n, f[0], g, (p == 0) ? -1 : ((p == 1) ? 0 : n - 1));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule